// File: doc/BRIEF.md
# Alternate-Space Decoder with Flush and Power-Down Sequencer

This block sits next to a processor's load/store unit. Every alternate-space access carries an 8-bit space identifier. The block turns it into a region code for the memory pipeline, or into a maintenance command. Only the low six identifier bits are decoded. Identifiers the block does not recognise raise a flag back to the pipeline.

Stores to the flush identifiers start a sequencer. It raises request lines towards the instruction cache, the data cache and the translation buffer. Each request stays up until its acknowledge arrives.

- Cache-only flushes run entirely in the background and never stall the pipeline.
- The combined flush stalls the pipeline only while the translation buffer is being cleared. It then launches both cache flushes in the background.
- A flush command that arrives while earlier work is outstanding is held off with a stall.

A write to a designated special register puts the core to sleep. The pipeline is stalled and the core clock enable drops until an interrupt is pending. On wake-up, the clock enable returns one cycle before the stall is released.

Top module: `alt_space_ctrl`

## Requirements
- R1: Identifier bits 7 and 6 have no effect: an identifier and the same identifier with either or both of those bits set give the same region code, flags and flush behaviour.
- R2: With `acc_valid` high, `region_code` is combinationally:
  - 1 for 0x01, 2 for 0x02, and 3 for 0x08 to 0x0B;
  - 4, 5, 6 and 7 for 0x0C, 0x0D, 0x0E and 0x0F;
  - 8 for the flush identifiers 0x10, 0x11, 0x13 and 0x18;
  - 9 for 0x19 and 10 for 0x1C.
- R3: With `acc_valid` high and any other identifier, `space_unimpl` is 1 and `region_code` is 0. With `acc_valid` low, `space_unimpl` is 0.
- R4: An accepted store to 0x10 or 0x13 raises `ic_flush_req` and `dc_flush_req` on the next cycle. `tlb_flush_req` stays low and there is no stall.
- R5: An accepted store to 0x11 raises only `dc_flush_req` on the next cycle.
- R6: An accepted store to 0x18 raises `tlb_flush_req` and `pipe_stall` on the next cycle, with both cache requests low. On the cycle after `tlb_flush_ack` is seen, the stall drops and both cache requests rise.
- R7: Each flush request stays high until its acknowledge is sampled, and is low on the following cycle.
- R8: `flush_busy` is high from the cycle after a flush is accepted until the cycle after the last outstanding acknowledge.
- R9: A flush store presented while `flush_busy` is high raises `pipe_stall` in the same cycle and starts nothing. It is accepted in the first cycle in which the block is no longer busy.
- R10: A read of a flush identifier raises `rdata_zero` and starts no flush. A store to a non-flush identifier starts no flush.
- R11: A write with `sreg_idx` equal to `PD_REG_IDX` (19) lowers `core_clk_en` and raises `pipe_stall` on the next cycle. Both hold until `irq_pending` is seen. A write to any other index has no effect.
- R12: The cycle after `irq_pending` is seen in sleep, `core_clk_en` is 1 and `pipe_stall` is still 1. On the following cycle `pipe_stall` is 0.
- R13: After reset, all flush requests and `flush_busy` are 0, `core_clk_en` is 1 and `pipe_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (ungated) |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Alternate-space access present |
| acc_write | input | 1 | Access is a store |
| acc_asi | input | ASI_W (8) | Space identifier of the access |
| region_code | output | 4 | Decoded region, 0 when undecoded or idle |
| space_unimpl | output | 1 | Identifier not implemented |
| rdata_zero | output | 1 | Read of a flush identifier returns zero |
| sreg_wr | input | 1 | Special-register write strobe |
| sreg_idx | input | SREG_W (5) | Special-register index |
| irq_pending | input | 1 | Interrupt pending, wakes from sleep |
| ic_flush_req | output | 1 | Instruction-cache flush request |
| ic_flush_ack | input | 1 | Instruction-cache flush done |
| dc_flush_req | output | 1 | Data-cache flush request |
| dc_flush_ack | input | 1 | Data-cache flush done |
| tlb_flush_req | output | 1 | Translation-buffer flush request |
| tlb_flush_ack | input | 1 | Translation-buffer flush done |
| flush_busy | output | 1 | Flush work outstanding |
| core_clk_en | output | 1 | Core clock enable for the external gate |
| pipe_stall | output | 1 | Hold the pipeline |

## Verification
The bench builds the block with its default parameters: an 8-bit identifier and special-register index 19 as the sleep trigger. The 8-bit identifier lets the bench drive values with the top two bits set, so the masking of bits 7 and 6 is exercised on decode and on a combined flush. The 5-bit register index lets the bench write both the sleep register and a neighbouring index. The acknowledges are driven by hand, so each request can be held for several cycles, overlap with a second command can be forced, and the translation-buffer phase can be stretched to observe the stall ending exactly one cycle after the acknowledge.

// File: rtl/alt_space_pkg.sv
package alt_space_pkg;

    localparam int ID_BITS  = 6;
    localparam int REGION_W = 4;

    typedef enum logic [REGION_W-1:0] {
        RG_NONE   = 4'd0,
        RG_MISS   = 4'd1,
        RG_SYSCTL = 4'd2,
        RG_CACHED = 4'd3,
        RG_ITAG   = 4'd4,
        RG_IDATA  = 4'd5,
        RG_DTAG   = 4'd6,
        RG_DDATA  = 4'd7,
        RG_FLUSH  = 4'd8,
        RG_MMUREG = 4'd9,
        RG_MMUBYP = 4'd10
    } region_e;

    typedef enum logic [1:0] {
        FL_NONE = 2'd0,
        FL_DC   = 2'd1,
        FL_IDC  = 2'd2,
        FL_ALL  = 2'd3
    } flush_e;

    typedef enum logic [1:0] {
        PD_RUN   = 2'd0,
        PD_SLEEP = 2'd1,
        PD_WAKE  = 2'd2
    } pd_e;

    typedef struct packed {
        region_e region;
        flush_e  flush;
        logic    unimpl;
    } dec_t;

    function automatic dec_t decode_id(input logic [ID_BITS-1:0] id);
        dec_t d;
        d = '{region: RG_NONE, flush: FL_NONE, unimpl: 1'b0};
        case (id)
            6'h01: d.region = RG_MISS;
            6'h02: d.region = RG_SYSCTL;
            6'h08, 6'h09, 6'h0A, 6'h0B: d.region = RG_CACHED;
            6'h0C: d.region = RG_ITAG;
            6'h0D: d.region = RG_IDATA;
            6'h0E: d.region = RG_DTAG;
            6'h0F: d.region = RG_DDATA;
            6'h10, 6'h13: begin d.region = RG_FLUSH; d.flush = FL_IDC; end
            6'h11: begin d.region = RG_FLUSH; d.flush = FL_DC; end
            6'h18: begin d.region = RG_FLUSH; d.flush = FL_ALL; end
            6'h19: d.region = RG_MMUREG;
            6'h1C: d.region = RG_MMUBYP;
            default: d.unimpl = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/asi_decoder.sv
module asi_decoder
    import alt_space_pkg::*;
#(
    parameter int ASI_W = 8
) (
    input  logic             valid,
    input  logic             write,
    input  logic [ASI_W-1:0] asi,
    output region_e          region,
    output flush_e           cmd,
    output logic             unimpl,
    output logic             rd_zero
);
    dec_t d;

    always_comb begin
        d       = decode_id(asi[ID_BITS-1:0]);
        region  = valid ? d.region : RG_NONE;
        unimpl  = valid & d.unimpl;
        rd_zero = valid & ~write & (d.region == RG_FLUSH);
        cmd     = (valid & write) ? d.flush : FL_NONE;
    end

endmodule

// File: rtl/flush_seq.sv
module flush_seq
    import alt_space_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flush_e cmd,
    input  logic   ic_ack,
    input  logic   dc_ack,
    input  logic   tlb_ack,
    output logic   ic_req,
    output logic   dc_req,
    output logic   tlb_req,
    output logic   busy,
    output logic   stall
);
    logic defer_caches;
    logic has_cmd;
    logic start;

    always_comb begin
        busy    = ic_req | dc_req | tlb_req | defer_caches;
        has_cmd = (cmd != FL_NONE);
        start   = has_cmd & ~busy;
        stall   = tlb_req | (has_cmd & busy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ic_req       <= 1'b0;
            dc_req       <= 1'b0;
            tlb_req      <= 1'b0;
            defer_caches <= 1'b0;
        end else begin
            if (ic_req && ic_ack)   ic_req  <= 1'b0;
            if (dc_req && dc_ack)   dc_req  <= 1'b0;
            if (tlb_req && tlb_ack) begin
                tlb_req <= 1'b0;
                if (defer_caches) begin
                    ic_req       <= 1'b1;
                    dc_req       <= 1'b1;
                    defer_caches <= 1'b0;
                end
            end
            if (start) begin
                case (cmd)
                    FL_DC:  dc_req <= 1'b1;
                    FL_IDC: begin ic_req <= 1'b1; dc_req <= 1'b1; end
                    FL_ALL: begin tlb_req <= 1'b1; defer_caches <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    AST_IC_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        ic_req && !ic_ack |=> ic_req); // R7
    AST_DC_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        dc_req && !dc_ack |=> dc_req); // R7
    AST_TLB_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        tlb_req && !tlb_ack |=> tlb_req); // R7
    AST_TLB_DROP: assert property (@(posedge clk) disable iff (rst)
        tlb_req && tlb_ack |=> !tlb_req); // R7
    AST_CACHES_AFTER_TLB: assert property (@(posedge clk) disable iff (rst)
        tlb_req |-> !ic_req && !dc_req); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        $rose(tlb_req) |-> !$past(busy)); // R9

endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
    import alt_space_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic irq,
    output logic clk_en,
    output logic stall
);
    pd_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PD_RUN;
        end else begin
            case (state)
                PD_RUN:   if (enter) state <= PD_SLEEP;
                PD_SLEEP: if (irq)   state <= PD_WAKE;
                default:             state <= PD_RUN;
            endcase
        end
    end

    always_comb begin
        clk_en = (state != PD_SLEEP);
        stall  = (state != PD_RUN);
    end

    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !clk_en && !irq |=> !clk_en); // R11
    AST_CLKEN_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> stall); // R12
    AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |=> !stall); // R12

endmodule

// File: rtl/alt_space_ctrl.sv
module alt_space_ctrl
    import alt_space_pkg::*;
#(
    parameter int ASI_W      = 8,
    parameter int SREG_W     = 5,
    parameter int PD_REG_IDX = 19
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ASI_W-1:0]    acc_asi,
    output logic [REGION_W-1:0] region_code,
    output logic                space_unimpl,
    output logic                rdata_zero,
    input  logic                sreg_wr,
    input  logic [SREG_W-1:0]   sreg_idx,
    input  logic                irq_pending,
    output logic                ic_flush_req,
    input  logic                ic_flush_ack,
    output logic                dc_flush_req,
    input  logic                dc_flush_ack,
    output logic                tlb_flush_req,
    input  logic                tlb_flush_ack,
    output logic                flush_busy,
    output logic                core_clk_en,
    output logic                pipe_stall
);
    localparam logic [SREG_W-1:0] PD_IDX = SREG_W'(PD_REG_IDX);

    region_e region;
    flush_e  cmd;
    logic    fs_stall;
    logic    pd_stall;
    logic    pd_enter;

    asi_decoder #(.ASI_W(ASI_W)) u_dec (
        .valid   (acc_valid),
        .write   (acc_write),
        .asi     (acc_asi),
        .region  (region),
        .cmd     (cmd),
        .unimpl  (space_unimpl),
        .rd_zero (rdata_zero)
    );

    flush_seq u_fs (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .ic_ack  (ic_flush_ack),
        .dc_ack  (dc_flush_ack),
        .tlb_ack (tlb_flush_ack),
        .ic_req  (ic_flush_req),
        .dc_req  (dc_flush_req),
        .tlb_req (tlb_flush_req),
        .busy    (flush_busy),
        .stall   (fs_stall)
    );

    assign pd_enter = sreg_wr & (sreg_idx == PD_IDX);

    pd_ctrl u_pd (
        .clk    (clk),
        .rst    (rst),
        .enter  (pd_enter),
        .irq    (irq_pending),
        .clk_en (core_clk_en),
        .stall  (pd_stall)
    );

    assign region_code = region;
    assign pipe_stall  = fs_stall | pd_stall;

    AST_UNIMPL_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        space_unimpl |-> acc_valid && region_code == '0); // R3
    AST_READ_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        rdata_zero && !flush_busy |=> !ic_flush_req && !dc_flush_req && !tlb_flush_req); // R10

endmodule

// File: tb/test_alt_space_ctrl.sv
module test_alt_space_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;
    // {identifier, expected region, expected unimpl, expected rdata_zero}
    localparam logic [13:0] VEC [NVEC] = '{
        {8'h01, 4'd1, 1'b0, 1'b0}, {8'hC1, 4'd1, 1'b0, 1'b0},
        {8'h02, 4'd2, 1'b0, 1'b0}, {8'h08, 4'd3, 1'b0, 1'b0},
        {8'h0B, 4'd3, 1'b0, 1'b0}, {8'h4A, 4'd3, 1'b0, 1'b0},
        {8'h0C, 4'd4, 1'b0, 1'b0}, {8'h0D, 4'd5, 1'b0, 1'b0},
        {8'h0E, 4'd6, 1'b0, 1'b0}, {8'h0F, 4'd7, 1'b0, 1'b0},
        {8'h19, 4'd9, 1'b0, 1'b0}, {8'h1C, 4'd10, 1'b0, 1'b0},
        {8'h9C, 4'd10, 1'b0, 1'b0}, {8'h10, 4'd8, 1'b0, 1'b1},
        {8'h53, 4'd8, 1'b0, 1'b1}, {8'h18, 4'd8, 1'b0, 1'b1},
        {8'h11, 4'd8, 1'b0, 1'b1}, {8'h00, 4'd0, 1'b1, 1'b0},
        {8'h14, 4'd0, 1'b1, 1'b0}, {8'h3F, 4'd0, 1'b1, 1'b0},
        {8'h12, 4'd0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0] acc_asi = '0;
    logic [3:0] region_code;
    logic space_unimpl, rdata_zero;
    logic sreg_wr = 1'b0;
    logic [4:0] sreg_idx = '0;
    logic irq_pending = 1'b0;
    logic ic_flush_req, dc_flush_req, tlb_flush_req;
    logic ic_flush_ack = 1'b0, dc_flush_ack = 1'b0, tlb_flush_ack = 1'b0;
    logic flush_busy, core_clk_en, pipe_stall;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alt_space_ctrl #(.ASI_W(8), .SREG_W(5), .PD_REG_IDX(19)) i_alt_space_ctrl (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_asi(acc_asi), .region_code(region_code), .space_unimpl(space_unimpl),
        .rdata_zero(rdata_zero), .sreg_wr(sreg_wr), .sreg_idx(sreg_idx),
        .irq_pending(irq_pending), .ic_flush_req(ic_flush_req),
        .ic_flush_ack(ic_flush_ack), .dc_flush_req(dc_flush_req),
        .dc_flush_ack(dc_flush_ack), .tlb_flush_req(tlb_flush_req),
        .tlb_flush_ack(tlb_flush_ack), .flush_busy(flush_busy),
        .core_clk_en(core_clk_en), .pipe_stall(pipe_stall)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // flush request vector {tlb, ic, dc}
    function automatic int reqs();
        return {tlb_flush_req, ic_flush_req, dc_flush_req};
    endfunction

    task automatic store(input logic [7:0] id);
        acc_valid = 1'b1; acc_write = 1'b1; acc_asi = id;
    endtask

    task automatic idle();
        acc_valid = 1'b0; acc_write = 1'b0; acc_asi = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        #1;
        // R13 reset state
        chk("R13 reqs", reqs(), 0);
        chk("R13 busy", flush_busy, 0);
        chk("R13 clk_en", core_clk_en, 1);
        chk("R13 stall", pipe_stall, 0);
        chk("R3 idle unimpl", space_unimpl, 0);

        // R1 R2 R3 R10 decode table, reads only
        for (int i = 0; i < NVEC; i++) begin
            acc_valid = 1'b1; acc_write = 1'b0; acc_asi = VEC[i][13:6];
            #1;
            chk("R2 region", region_code, int'(VEC[i][5:2]));
            chk("R3 unimpl", space_unimpl, int'(VEC[i][1]));
            chk("R10 rdata_zero", rdata_zero, int'(VEC[i][0]));
            tick();
            idle();
            #1;
            chk("R10 read starts nothing", reqs(), 0);
        end

        // R10 store to non-flush identifier
        store(8'h02); tick(); idle(); #1;
        chk("R10 store non-flush", reqs(), 0);

        // R4 store 0x10
        store(8'h10); #1;
        chk("R4 no stall", pipe_stall, 0);
        tick(); idle(); #1;
        chk("R4 ic+dc req", reqs(), 3);
        chk("R8 busy", flush_busy, 1);
        chk("R4 no stall bg", pipe_stall, 0);
        tick();
        chk("R7 held", reqs(), 3);
        ic_flush_ack = 1'b1; tick(); ic_flush_ack = 1'b0; #1;
        chk("R7 ic drop", reqs(), 1);
        chk("R8 busy dc left", flush_busy, 1);
        dc_flush_ack = 1'b1; tick(); dc_flush_ack = 1'b0; #1;
        chk("R7 dc drop", reqs(), 0);
        chk("R8 busy clear", flush_busy, 0);

        // R5 R1 store 0x51 acts as 0x11, then R9 overlap with 0x13
        store(8'h51); tick(); idle(); #1;
        chk("R5 dc only", reqs(), 1);
        store(8'h13); #1;
        chk("R9 stall busy", pipe_stall, 1);
        tick(); #1;
        chk("R9 no new req", reqs(), 1);
        dc_flush_ack = 1'b1; tick(); dc_flush_ack = 1'b0; #1;
        chk("R9 still held out", reqs(), 0);
        chk("R9 stall clears", pipe_stall, 0);
        tick(); idle(); #1;
        chk("R9 accepted after", reqs(), 3);
        ic_flush_ack = 1'b1; dc_flush_ack = 1'b1; tick();
        ic_flush_ack = 1'b0; dc_flush_ack = 1'b0; #1;
        chk("R8 done", flush_busy, 0);

        // R6 R1 store 0x98 acts as 0x18
        store(8'h98); #1;
        chk("R6 no stall on accept", pipe_stall, 0);
        tick(); idle(); #1;
        chk("R6 tlb only", reqs(), 4);
        chk("R6 stall", pipe_stall, 1);
        tick(); tick();
        chk("R6 caches wait", reqs(), 4);
        chk("R6 stall held", pipe_stall, 1);
        tlb_flush_ack = 1'b1; tick(); tlb_flush_ack = 1'b0; #1;
        chk("R6 caches start", reqs(), 3);
        chk("R6 stall drops", pipe_stall, 0);
        chk("R8 busy bg", flush_busy, 1);
        ic_flush_ack = 1'b1; dc_flush_ack = 1'b1; tick();
        ic_flush_ack = 1'b0; dc_flush_ack = 1'b0; #1;
        chk("R8 bg done", flush_busy, 0);

        // R11 wrong index ignored
        sreg_wr = 1'b1; sreg_idx = 5'd18; tick(); sreg_wr = 1'b0; #1;
        chk("R11 other idx clk_en", core_clk_en, 1);
        chk("R11 other idx stall", pipe_stall, 0);

        // R11 R12 power-down
        sreg_wr = 1'b1; sreg_idx = 5'd19; tick(); sreg_wr = 1'b0; #1;
        chk("R11 clk_en low", core_clk_en, 0);
        chk("R11 stall", pipe_stall, 1);
        tick(); tick(); tick();
        chk("R11 still asleep", core_clk_en, 0);
        irq_pending = 1'b1; tick(); irq_pending = 1'b0; #1;
        chk("R12 clk_en back", core_clk_en, 1);
        chk("R12 stall kept", pipe_stall, 1);
        tick();
        chk("R12 stall released", pipe_stall, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule